// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port of a memory device. A test controller steps it with a test clock and a mode-select line, and shifts serial data in on the data input and out on the data output. Inside are the sixteen-state port controller, a three-bit instruction register, a single-bit pass-through register, a 32-bit identification register and a boundary register whose length is set by parameters. The boundary register has one cell for each device pin, plus optional cells that have no pin and always capture a fixed value.

The loaded instruction decides three things: which data register sits on the serial path, whether the device outputs are driven from the boundary update latches, and whether every device output is forced to high impedance. The functional inputs always stay connected to the core. This block only samples them. The pad ring uses `pin_drive_sel_o` and `pin_hiz_o` to pick what each output pin does. `tdo_oe_o` is the enable for the pad of the serial output.

Top module: `jtag_tap_ctl`

## Requirements
- R1: After `trst_ni` is asserted, the active instruction is the identify instruction, code 3'b001. A data scan with no instruction load then shifts out `ID_VALUE`, least significant bit first. In this state `pin_drive_sel_o` and `pin_hiz_o` are both 0.
- R2: Five consecutive rising test-clock edges with mode-select high return the controller to its reset state from any state. The active instruction then becomes 3'b001 again.
- R3: During an instruction scan, the first three bits shifted out are the captured value 3'b001, least significant bit first. The instruction register is loaded only on the falling edge in the instruction-update state.
- R4: Code 3'b111 selects the single-bit pass-through register. It captures 0, so a scan returns 0 followed by the input bits delayed by one position.
- R5: The unassigned codes 3'b011, 3'b101 and 3'b110 behave exactly like 3'b111.
- R6: Code 3'b100 (sample/preload) selects the boundary register. Cells 0 to NUM_PINS-1 capture `pin_sample_i`, and the cells above them capture the low bits of `FIXED_VAL`. Cell 0 is shifted out first. Under this code both pin controls stay 0.
- R7: Under 3'b100, the falling edge in the data-update state copies boundary cells 0 to NUM_PINS-1 into `pin_drive_o`. These values remain after a change to 3'b000.
- R8: Code 3'b000 (external test) sets `pin_drive_sel_o` to 1, keeps the boundary register on the scan path, and still captures `pin_sample_i`.
- R9: Code 3'b010 (sample with outputs off) sets `pin_hiz_o` to 1 and `pin_drive_sel_o` to 0, and keeps the boundary register on the scan path.
- R10: `tdo_oe_o` is 1 only while the controller is in a shift state. `tdo_o` changes on falling test-clock edges.
- R11: `pin_drive_o` changes only at the data-update falling edge while a boundary code is active. It holds its value while a new pattern is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tms_i | input | 1 | Mode select, sampled on the rising edge |
| tdi_i | input | 1 | Serial data in |
| trst_ni | input | 1 | Asynchronous test reset, active low |
| pin_sample_i | input | NUM_PINS | Present values of the device pins |
| tdo_o | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe_o | output | 1 | Output enable for the serial-out pad |
| pin_drive_o | output | NUM_PINS | Values held in the boundary update latches |
| pin_drive_sel_o | output | 1 | Outputs take `pin_drive_o` instead of core data |
| pin_hiz_o | output | 1 | All device outputs forced to high impedance |

## Verification
Under the external-test code, driving the pins from the update latches and shifting a new boundary pattern happen in the same test-clock cycles. A fault here would let the half-shifted pattern leak onto the outputs. The bench preloads a known pattern, switches to external test and shifts a different pattern. It compares `pin_drive_o` against the preloaded value at every shift step, and against the new pattern only after the update edge. The bench also holds the pin inputs at a value unrelated to either pattern. This checks that capture under external test returns the pins and not the driven values.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
   } tap_state_e;

   typedef enum logic [1:0] {SEL_PASS, SEL_IDENT, SEL_BOUND} dr_sel_e;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
   localparam logic [IR_W-1:0] OP_PASS    = 3'b111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);
   tap_state_e nxt;

   always_comb begin
      case (state)
         ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
         ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
         ST_DR_SHIFT: nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
         ST_DR_EX1:   nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: nxt = tms ? ST_DR_EX2   : ST_DR_PAUSE;
         ST_DR_EX2:   nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
         ST_IR_SHIFT: nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
         ST_IR_EX1:   nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: nxt = tms ? ST_IR_EX2   : ST_IR_PAUSE;
         ST_IR_EX2:   nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
         default:     nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= nxt;
   end

   // checker-only run counter of mode-select highs
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        hi_run <= 3'd0;
      else if (!tms)      hi_run <= 3'd0;
      else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
   end

   // R2
   five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run == 3'd5) |-> (state == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import jtag_tap_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_tdo
);
   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                    ir_sr <= '0;
      else if (state == ST_IR_CAP)    ir_sr <= IR_CAPTURE;
      else if (state == ST_IR_SHIFT)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                    ir_q <= OP_IDENT;
      else if (state == ST_RESET)     ir_q <= OP_IDENT;
      else if (state == ST_IR_UPD)    ir_q <= ir_sr;
   end

   assign ir_tdo = ir_sr[0];

   // R1
   reset_loads_ident_chk: assert property (@(negedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (ir_q == OP_IDENT));
   // R3
   ir_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
      (state != ST_RESET && state != ST_IR_UPD) |=> $stable(ir_q));
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
   import jtag_tap_pkg::*;
#(
   parameter int          NUM_PINS  = 8,
   parameter int          NUM_FIXED = 2,
   parameter logic [31:0] FIXED_VAL = 32'h2,
   localparam int         BSR_W     = NUM_PINS + NUM_FIXED
) (
   input  logic                tck,
   input  logic                trst_n,
   input  tap_state_e          state,
   input  logic                sel_en,
   input  logic                tdi,
   input  logic [NUM_PINS-1:0] pin_sample,
   output logic                bsr_tdo,
   output logic [NUM_PINS-1:0] upd_q
);
   logic [BSR_W-1:0] cap_val;
   logic [BSR_W-1:0] sr;

   if (NUM_FIXED > 0) begin : g_fixed
      assign cap_val = {FIXED_VAL[NUM_FIXED-1:0], pin_sample};
   end else begin : g_pins_only
      assign cap_val = pin_sample;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                             sr <= '0;
      else if (sel_en && state == ST_DR_CAP)   sr <= cap_val;
      else if (sel_en && state == ST_DR_SHIFT) sr <= {tdi, sr[BSR_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                           upd_q <= '0;
      else if (sel_en && state == ST_DR_UPD) upd_q <= sr[NUM_PINS-1:0];
   end

   assign bsr_tdo = sr[0];

   // R11
   drive_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
      !(sel_en && state == ST_DR_UPD) |=> $stable(upd_q));
endmodule

// File: rtl/jtag_tap_ctl.sv
module jtag_tap_ctl
   import jtag_tap_pkg::*;
#(
   parameter int          NUM_PINS  = 8,
   parameter int          NUM_FIXED = 2,
   parameter logic [31:0] FIXED_VAL = 32'h2,
   parameter logic [31:0] ID_VALUE  = 32'h4B7A_2C1D
) (
   input  logic                tck_i,
   input  logic                tms_i,
   input  logic                tdi_i,
   input  logic                trst_ni,
   input  logic [NUM_PINS-1:0] pin_sample_i,
   output logic                tdo_o,
   output logic                tdo_oe_o,
   output logic [NUM_PINS-1:0] pin_drive_o,
   output logic                pin_drive_sel_o,
   output logic                pin_hiz_o
);
   if (NUM_PINS < 2) begin : g_bad_pins
      $error("NUM_PINS must be at least 2");
   end
   if (NUM_FIXED < 0 || NUM_FIXED > 32) begin : g_bad_fixed
      $error("NUM_FIXED must lie in 0..32");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("ID_VALUE bit 0 must be 1");
   end

   tap_state_e      state;
   logic [IR_W-1:0] ir_q;
   logic            ir_tdo, bsr_tdo;
   dr_sel_e         dr_sel;
   logic            pass_q;
   logic [31:0]     id_sr;

   tap_fsm u_fsm (.tck(tck_i), .trst_n(trst_ni), .tms(tms_i), .state(state));

   tap_ir u_ir (.tck(tck_i), .trst_n(trst_ni), .state(state), .tdi(tdi_i),
                .ir_q(ir_q), .ir_tdo(ir_tdo));

   always_comb begin
      case (ir_q)
         OP_EXTEST, OP_SAMPLE, OP_SAMPLEZ: dr_sel = SEL_BOUND;
         OP_IDENT:                         dr_sel = SEL_IDENT;
         default:                          dr_sel = SEL_PASS;
      endcase
   end

   tap_bsr #(.NUM_PINS(NUM_PINS), .NUM_FIXED(NUM_FIXED), .FIXED_VAL(FIXED_VAL)) u_bsr (
      .tck(tck_i), .trst_n(trst_ni), .state(state), .sel_en(dr_sel == SEL_BOUND),
      .tdi(tdi_i), .pin_sample(pin_sample_i), .bsr_tdo(bsr_tdo), .upd_q(pin_drive_o));

   always_ff @(posedge tck_i or negedge trst_ni) begin
      if (!trst_ni) begin
         pass_q <= 1'b0;
         id_sr  <= '0;
      end else begin
         if (dr_sel == SEL_PASS && state == ST_DR_CAP)        pass_q <= 1'b0;
         else if (dr_sel == SEL_PASS && state == ST_DR_SHIFT) pass_q <= tdi_i;
         if (dr_sel == SEL_IDENT && state == ST_DR_CAP)        id_sr <= ID_VALUE;
         else if (dr_sel == SEL_IDENT && state == ST_DR_SHIFT) id_sr <= {tdi_i, id_sr[31:1]};
      end
   end

   logic tdo_d;
   always_comb begin
      tdo_d = 1'b0;
      if (state == ST_IR_SHIFT) tdo_d = ir_tdo;
      else if (state == ST_DR_SHIFT) begin
         case (dr_sel)
            SEL_BOUND: tdo_d = bsr_tdo;
            SEL_IDENT: tdo_d = id_sr[0];
            default:   tdo_d = pass_q;
         endcase
      end
   end

   always_ff @(negedge tck_i or negedge trst_ni) begin
      if (!trst_ni) begin
         tdo_o    <= 1'b0;
         tdo_oe_o <= 1'b0;
      end else begin
         tdo_o    <= tdo_d;
         tdo_oe_o <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
      end
   end

   assign pin_drive_sel_o = (ir_q == OP_EXTEST);
   assign pin_hiz_o       = (ir_q == OP_SAMPLEZ);

   // R10
   tdo_enable_chk: assert property (@(posedge tck_i) disable iff (!trst_ni)
      tdo_oe_o == ((state == ST_IR_SHIFT) || (state == ST_DR_SHIFT)));
endmodule

// File: tb/sim_jtag_tap_ctl.sv
module sim_jtag_tap_ctl;
   localparam int          P      = 20;
   localparam int          NP     = 8;
   localparam logic [31:0] ID     = 32'h4B7A_2C1D;
   localparam logic [1:0]  FIXED  = 2'b10;
   localparam int          SLEN   = 48;

   logic          tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
   logic [NP-1:0] pins = 8'h00;
   logic          tdo, tdo_oe, drv_sel, hiz;
   logic [NP-1:0] drv;
   int            n_run = 0, n_fail = 0;

   jtag_tap_ctl #(.NUM_PINS(NP), .NUM_FIXED(2), .FIXED_VAL(32'h2), .ID_VALUE(ID)) u0 (
      .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .trst_ni(trst_n), .pin_sample_i(pins),
      .tdo_o(tdo), .tdo_oe_o(tdo_oe), .pin_drive_o(drv), .pin_drive_sel_o(drv_sel),
      .pin_hiz_o(hiz));

   always #(P/2) tck = ~tck;

   // {opcode, kind (0 pass, 1 ident, 2 boundary), drive_sel, hiz}
   localparam logic [6:0] VEC [8] = '{
      {3'b111, 2'd0, 1'b0, 1'b0}, {3'b011, 2'd0, 1'b0, 1'b0},
      {3'b101, 2'd0, 1'b0, 1'b0}, {3'b110, 2'd0, 1'b0, 1'b0},
      {3'b001, 2'd1, 1'b0, 1'b0}, {3'b100, 2'd2, 1'b0, 1'b0},
      {3'b000, 2'd2, 1'b1, 1'b0}, {3'b010, 2'd2, 1'b0, 1'b1}};

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'b111:  return "R4";
         3'b001:  return "R1";
         3'b100:  return "R6";
         3'b000:  return "R8";
         3'b010:  return "R9";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o, output logic oe);
      @(negedge tck);
      #(P/4);
      o = tdo; oe = tdo_oe;
      tms = m; tdi = d;
   endtask

   task automatic idle(input int k);
      logic o, e;
      for (int i = 0; i < k; i++) step(1'b0, 1'b0, o, e);
   endtask

   task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
      logic o, e;
      step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
      for (int i = 0; i < 3; i++) begin
         step(i == 2, op[i], o, e);
         cap[i] = o;
      end
      step(1, 0, o, e); step(0, 0, o, e); idle(1);
   endtask

   task automatic shift_dr(input int len, input logic [63:0] din, output logic [63:0] dout,
                           output logic oe_all, output logic drv_held);
      logic o, e;
      logic [NP-1:0] d0;
      dout = '0; oe_all = 1'b1; drv_held = 1'b1;
      step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
      d0 = drv;
      for (int i = 0; i < len; i++) begin
         step(i == len - 1, din[i], o, e);
         dout[i] = o;
         if (!e) oe_all = 1'b0;
         if (drv !== d0) drv_held = 1'b0;
      end
      step(1, 0, o, e); step(0, 0, o, e); idle(1);
   endtask

   function automatic logic [63:0] expect_out(input logic [1:0] kind, input logic [63:0] din,
                                              input logic [NP-1:0] p);
      logic [63:0] r;
      case (kind)
         2'd0:    r = din << 1;
         2'd1:    r = (din << 32) | {32'h0, ID};
         default: r = (din << (NP + 2)) | {54'h0, FIXED, p};
      endcase
      return r & ((64'h1 << SLEN) - 1);
   endfunction

   task automatic do_reset();
      trst_n = 1'b0; tms = 1'b1;
      #(P * 2 + 3);
      trst_n = 1'b1;
      idle(2);
   endtask

   initial begin
      #(P * 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [2:0]  cap;
      logic [63:0] dout, din;
      logic        oe_all, held, o, e;

      do_reset();
      // R1 reset state
      chk("R1 drive_sel", {63'h0, drv_sel}, 64'h0);
      chk("R1 hiz", {63'h0, hiz}, 64'h0);
      chk("R10 oe idle", {63'h0, tdo_oe}, 64'h0);
      din = 64'h0000_5A3C_96F0_E11D;
      shift_dr(SLEN, din, dout, oe_all, held);
      chk("R1 ident after reset", dout, expect_out(2'd1, din, pins));
      chk("R10 oe during shift", {63'h0, oe_all}, 64'h1);
      chk("R10 oe after shift", {63'h0, tdo_oe}, 64'h0);

      // R3 instruction capture
      load_ir(3'b111, cap);
      chk("R3 ir capture", {61'h0, cap}, 64'h1);

      // table walk
      for (int v = 0; v < 8; v++) begin
         logic [2:0] op;
         logic [1:0] kind;
         op = VEC[v][6:4]; kind = VEC[v][3:2];
         pins = 8'h3C ^ 8'(v * 37);
         load_ir(op, cap);
         chk({tag_of(op), " drive_sel"}, {63'h0, drv_sel}, {63'h0, VEC[v][1]});
         chk({tag_of(op), " hiz"}, {63'h0, hiz}, {63'h0, VEC[v][0]});
         din = {32'h0000_9E37, 32'(v) * 32'h2545_F491};
         shift_dr(SLEN, din, dout, oe_all, held);
         chk({tag_of(op), " scan data"}, dout, expect_out(kind, din, pins));
         chk("R10 oe in table", {63'h0, oe_all}, 64'h1);
      end

      // R2 five highs restore ident
      load_ir(3'b111, cap);
      for (int i = 0; i < 5; i++) step(1, 0, o, e);
      idle(2);
      din = 64'h0000_0000_1234_5678;
      shift_dr(SLEN, din, dout, oe_all, held);
      chk("R2 ident after tms reset", dout, expect_out(2'd1, din, pins));

      // R7 preload then external test
      load_ir(3'b100, cap);
      din = {54'h0, 2'b01, 8'hA5};
      shift_dr(NP + 2, din, dout, oe_all, held);
      chk("R7 preload drive", {56'h0, drv}, {56'h0, 8'hA5});
      chk("R7 no drive under sample", {63'h0, drv_sel}, 64'h0);
      load_ir(3'b000, cap);
      chk("R8 drive_sel", {63'h0, drv_sel}, 64'h1);
      chk("R7 preload kept", {56'h0, drv}, {56'h0, 8'hA5});

      // R11 shift under external test while driving
      pins = 8'h0F;
      din = {54'h0, 2'b11, 8'h5A};
      shift_dr(NP + 2, din, dout, oe_all, held);
      chk("R11 drive held while shifting", {63'h0, held}, 64'h1);
      chk("R11 drive after update", {56'h0, drv}, {56'h0, 8'h5A});
      chk("R8 capture pins", dout & 64'h3FF, {54'h0, FIXED, 8'h0F});

      // R1 async reset from external test
      do_reset();
      chk("R1 drive_sel after trst", {63'h0, drv_sel}, 64'h0);
      chk("R1 latches cleared", {56'h0, drv}, 64'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule